// File: doc/BRIEF.md
# Serial Word EEPROM Device Model

A synthesizable behavioural stand-in for a small serial EEPROM that stores 16-bit words and is reached over four wires: select, serial clock, data in and data out. It lets a host-side serial controller be built and checked against a device that answers the real command set, all inside one system clock domain. The three serial inputs are resynchronised to the system clock. A serial clock edge counts when the synchronised clock goes from low to high.

A command begins after select rises. It is a start bit of 1, then a two-bit opcode, then an address field of `ADDR_W` bits (6 or 8). Every field is sent most significant bit first. Depending on the command, sixteen data bits may follow. Reads answer with a dummy zero and then the stored word. Programming commands take effect on their final bit, with no busy period, and only while programming is enabled. The word store is a register array that comes out of reset fully erased (every word 16'hFFFF).

Top module: `ser_word_eeprom`

## Requirements
- R1: After reset, `sdo_o` is 0 and programming is disabled, so a write issued before any enable command leaves the addressed word at 16'hFFFF.
- R2: While selected and waiting for a start bit, data-in bits of 0 are ignored. The first 1 is taken as the start bit.
- R3: Opcode 2'b10 (read) answers with one 0 bit after the last address bit, then the 16-bit word MSB first. Each new bit appears only after a rising serial clock edge.
- R4: Opcode 2'b01 (write), with programming enabled, stores the 16 data bits that follow the address into the addressed word.
- R5: Opcode 2'b11 (erase), with programming enabled, sets the addressed word to 16'hFFFF and leaves the other words unchanged.
- R6: Opcode 2'b00 with the two top address bits 2'b10 (erase-all), with programming enabled, sets every word to 16'hFFFF.
- R7: Opcode 2'b00 with the two top address bits 2'b01 (write-all), with programming enabled, stores the 16 data bits that follow into every word.
- R8: Opcode 2'b00 with the two top address bits 2'b11 enables programming, and 2'b00 disables it. The lower address bits are don't-care. While programming is disabled, write, erase, write-all and erase-all change nothing.
- R9: Dropping select at any point aborts the command without changing memory and returns the decoder to waiting for a start bit. `sdo_o` is 0 while deselected.
- R10: The address field is `ADDR_W` bits wide. Words 0 and 2^ADDR_W-1 are distinct and fully usable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Device select, active high |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the device |
| sdo_o | output | 1 | Serial data out of the device, registered |

## Verification
The hardest situation to reach from the ports is a command cut short: select falling in the middle of the data bits of a write, or partway through a read. In either case no commit may happen, and the next command must still decode cleanly. The stimulus drives part of a write with programming enabled and then drops select. A read-back then shows that the word is unchanged. A read is also started and abandoned partway through, and the bench checks that data out falls to zero and that a following read returns correct data. The protection rules are reached by interleaving enable and disable commands with writes, erases and bulk commands, and comparing every read against a reference image.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DAT,
    ST_RD,
    ST_FIN
  } eep_st_e;

  localparam logic [1:0] OP_CTRL  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_WDIS = 2'b00;
  localparam logic [1:0] SUB_WALL = 2'b01;
  localparam logic [1:0] SUB_EALL = 2'b10;
  localparam logic [1:0] SUB_WEN  = 2'b11;
endpackage

// File: rtl/eep_in_sync.sv
module eep_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sel_s,
  output logic sdi_s,
  output logic sck_rise
);
  logic [STAGES-1:0] sel_sr, sck_sr, sdi_sr;
  logic              sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_sr   <= '0;
      sck_sr   <= '0;
      sdi_sr   <= '0;
      sck_prev <= 1'b0;
    end else begin
      sel_sr   <= {sel_sr[STAGES-2:0], sel_i};
      sck_sr   <= {sck_sr[STAGES-2:0], sck_i};
      sdi_sr   <= {sdi_sr[STAGES-2:0], sdi_i};
      sck_prev <= sck_sr[STAGES-1];
    end
  end

  assign sel_s    = sel_sr[STAGES-1];
  assign sdi_s    = sdi_sr[STAGES-1];
  assign sck_rise = sck_sr[STAGES-1] & ~sck_prev;
endmodule

// File: rtl/eep_word_store.sv
module eep_word_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_one,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= wr_data;
    end else if (wr_one) begin
      mem[addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_word <= '1;
    else     rd_word <= mem[addr];
  end
endmodule

// File: rtl/eep_cmd_fsm.sv
module eep_cmd_fsm
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_s,
  input  logic              sdi_s,
  input  logic              sck_rise,
  input  logic [WORD_W-1:0] rd_word,
  output logic              sdo,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_one,
  output logic              wr_all,
  output logic [WORD_W-1:0] wr_data,
  output logic              wen,
  output eep_st_e           st
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [1:0]        op;
  logic [WORD_W-1:0] shf;
  logic [ADDR_W-1:0] a_nxt;
  logic [WORD_W-1:0] d_nxt;

  always_comb begin
    a_nxt = {addr[ADDR_W-2:0], sdi_s};
    d_nxt = {shf[WORD_W-2:0], sdi_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      op      <= '0;
      addr    <= '0;
      shf     <= '0;
      sdo     <= 1'b0;
      wen     <= 1'b0;
      wr_one  <= 1'b0;
      wr_all  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_one <= 1'b0;
      wr_all <= 1'b0;
      if (!sel_s) begin
        st  <= ST_IDLE;
        cnt <= '0;
        sdo <= 1'b0;
      end else if (sck_rise) begin
        unique case (st)
          ST_IDLE: begin
            cnt <= '0;
            if (sdi_s) st <= ST_OPC;
          end
          ST_OPC: begin
            op  <= {op[0], sdi_s};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(1)) begin
              st  <= ST_ADR;
              cnt <= '0;
            end
          end
          ST_ADR: begin
            addr <= a_nxt;
            cnt  <= cnt + 1'b1;
            if (cnt == ADR_LAST) begin
              cnt <= '0;
              st  <= ST_FIN;
              unique case (op)
                OP_READ: begin
                  st  <= ST_RD;
                  sdo <= 1'b0;
                end
                OP_WRITE: st <= ST_DAT;
                OP_ERASE: begin
                  wr_one  <= wen;
                  wr_data <= '1;
                end
                default: begin
                  unique case (a_nxt[ADDR_W-1 -: 2])
                    SUB_WEN:  wen <= 1'b1;
                    SUB_WDIS: wen <= 1'b0;
                    SUB_EALL: begin
                      wr_all  <= wen;
                      wr_data <= '1;
                    end
                    default:  st <= ST_DAT;
                  endcase
                end
              endcase
            end
          end
          ST_DAT: begin
            shf <= d_nxt;
            cnt <= cnt + 1'b1;
            if (cnt == DAT_LAST) begin
              wr_data <= d_nxt;
              if (op == OP_WRITE) wr_one <= wen;
              else                wr_all <= wen;
              st <= ST_FIN;
            end
          end
          ST_RD: begin
            cnt <= cnt + 1'b1;
            if (cnt == '0) begin
              sdo <= rd_word[WORD_W-1];
              shf <= {rd_word[WORD_W-2:0], 1'b0};
            end else if (cnt == RD_LAST) begin
              sdo <= 1'b0;
              st  <= ST_FIN;
            end else begin
              sdo <= shf[WORD_W-1];
              shf <= {shf[WORD_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_word_eeprom.sv
module ser_word_eeprom
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o
);
  logic              sel_s, sdi_s, sck_rise;
  logic              wr_one, wr_all, wen;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wr_data, rd_word;
  eep_st_e           st;

  eep_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sel_i(sel_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .sel_s(sel_s), .sdi_s(sdi_s), .sck_rise(sck_rise)
  );

  eep_cmd_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
    .clk(clk), .rst(rst), .sel_s(sel_s), .sdi_s(sdi_s), .sck_rise(sck_rise),
    .rd_word(rd_word), .sdo(sdo_o), .addr(addr), .wr_one(wr_one),
    .wr_all(wr_all), .wr_data(wr_data), .wen(wen), .st(st)
  );

  eep_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .wr_one(wr_one), .wr_all(wr_all), .addr(addr),
    .wr_data(wr_data), .rd_word(rd_word)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    sel_s,
  input logic    sck_rise,
  input logic    sdo,
  input logic    wen,
  input logic    wr_one,
  input logic    wr_all,
  input eep_st_e st
);
  p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> !sdo);

  p_idle_on_drop_r9: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> (st == ST_IDLE));

  p_sdo_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> ($past(sck_rise) || !$past(sel_s)));

  p_wen_off_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wen);

  p_wen_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(wen) |-> ($past(sck_rise) && $past(sel_s)));

  p_commit_guard_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_one || wr_all) |-> wen);

  p_one_commit_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_one, wr_all}) <= 1);
endmodule

bind ser_word_eeprom eep_checker u_chk (
  .clk(clk), .rst(rst), .sel_s(sel_s), .sck_rise(sck_rise), .sdo(sdo_o),
  .wen(wen), .wr_one(wr_one), .wr_all(wr_all), .st(st)
);

// File: tb/test_ser_word_eeprom.sv
`timescale 1ns/1ps
module test_ser_word_eeprom;
  localparam int AW = 6;
  localparam int H  = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo;

  always #5 clk = ~clk;

  ser_word_eeprom #(.ADDR_W(AW)) i_ser_word_eeprom (
    .clk(clk), .rst(rst), .sel_i(sel), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo)
  );

  typedef struct { string tag; logic [16:0] v; } item_t;
  item_t exp_q[$];
  item_t act_q[$];

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] ref_mem [1 << AW];
  bit ref_wen = 0;

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      item_t a, e;
      wait (act_q.size() != 0);
      a = act_q.pop_front();
      e = exp_q.pop_front();
      chk(e.tag, a.v, e.v);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b);
    sdi = b; sck = 1'b0; wt(H);
    sck = 1'b1; wt(H);
  endtask

  task automatic head(input int zeros, input logic [1:0] op, input logic [AW-1:0] a);
    sel = 1'b1; wt(H);
    for (int i = 0; i < zeros; i++) bitx(1'b0);
    bitx(1'b1);
    bitx(op[1]); bitx(op[0]);
    for (int i = AW - 1; i >= 0; i--) bitx(a[i]);
  endtask

  task automatic finish_cmd;
    sck = 1'b0; sdi = 1'b0; wt(H);
    sel = 1'b0; wt(2 * H);
  endtask

  task automatic cmd(input int zeros, input logic [1:0] op, input logic [AW-1:0] a,
                     input bit has_d, input logic [15:0] d);
    head(zeros, op, a);
    if (has_d) for (int i = 15; i >= 0; i--) bitx(d[i]);
    finish_cmd();
    if (ref_wen) begin
      if (op == 2'b01) ref_mem[a] = d;
      if (op == 2'b11) ref_mem[a] = 16'hFFFF;
      if (op == 2'b00 && a[AW-1 -: 2] == 2'b10)
        foreach (ref_mem[i]) ref_mem[i] = 16'hFFFF;
      if (op == 2'b00 && a[AW-1 -: 2] == 2'b01)
        foreach (ref_mem[i]) ref_mem[i] = d;
    end
    if (op == 2'b00 && a[AW-1 -: 2] == 2'b11) ref_wen = 1;
    if (op == 2'b00 && a[AW-1 -: 2] == 2'b00) ref_wen = 0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    item_t e, g;
    e.tag = tag; e.v = {1'b0, ref_mem[a]};
    exp_q.push_back(e);
    head(0, 2'b10, a);
    g.tag = tag; g.v = '0;
    for (int i = 0; i < 17; i++) begin
      sck = 1'b0; wt(H);
      g.v = {g.v[15:0], sdo};
      sck = 1'b1; wt(H);
    end
    finish_cmd();
    act_q.push_back(g);
  endtask

  localparam logic [AW-1:0] A_WEN  = {2'b11, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] A_WDIS = {2'b00, {(AW-2){1'b1}}};
  localparam logic [AW-1:0] A_EALL = {2'b10, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] A_WALL = {2'b01, {(AW-2){1'b1}}};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    foreach (ref_mem[i]) ref_mem[i] = 16'hFFFF;
    wt(5); rst = 1'b0; wt(5);
    chk("R1 sdo after reset", {16'h0, sdo}, 17'h0);

    cmd(0, 2'b01, 6'd5, 1, 16'h1234);
    rd("R1 write before enable blocked", 6'd5);

    cmd(3, 2'b00, A_WEN, 0, 16'h0);
    cmd(2, 2'b01, 6'd5, 1, 16'hA55A);
    rd("R2 leading zeros then R4 write", 6'd5);

    cmd(0, 2'b01, 6'd63, 1, 16'h1357);
    cmd(0, 2'b01, 6'd0, 1, 16'h8001);
    rd("R10 top word", 6'd63);
    rd("R10 word zero", 6'd0);
    rd("R3 read order", 6'd5);

    cmd(0, 2'b11, 6'd5, 0, 16'h0);
    rd("R5 erased word", 6'd5);
    rd("R5 neighbour kept", 6'd63);

    cmd(0, 2'b00, A_WALL, 1, 16'hC3C3);
    rd("R7 write-all w0", 6'd0);
    rd("R7 write-all w17", 6'd17);
    rd("R7 write-all w63", 6'd63);

    cmd(0, 2'b01, 6'd17, 1, 16'h0F0F);
    cmd(0, 2'b00, A_EALL, 0, 16'h0);
    rd("R6 erase-all w17", 6'd17);
    rd("R6 erase-all w0", 6'd0);

    cmd(0, 2'b01, 6'd9, 1, 16'h2468);
    cmd(0, 2'b00, A_WDIS, 0, 16'h0);
    cmd(0, 2'b01, 6'd9, 1, 16'h1111);
    cmd(0, 2'b11, 6'd9, 0, 16'h0);
    cmd(0, 2'b00, A_EALL, 0, 16'h0);
    rd("R8 disabled blocks write/erase", 6'd9);

    cmd(0, 2'b00, A_WEN, 0, 16'h0);
    head(0, 2'b01, 6'd9);
    for (int i = 0; i < 8; i++) bitx(1'b1);
    finish_cmd();
    rd("R9 aborted write", 6'd9);

    head(0, 2'b10, 6'd9);
    for (int i = 0; i < 4; i++) bitx(1'b0);
    sel = 1'b0; wt(6);
    chk("R9 sdo low after drop", {16'h0, sdo}, 17'h0);
    sck = 1'b0; wt(2 * H);
    rd("R9 read after aborted read", 6'd9);

    wait (act_q.size() == 0);
    wt(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule